// File: doc/BRIEF.md
# Seconds Counter Timekeeper with Alarm

This block is a timekeeping core on a small register bus. It counts whole seconds in a 32-bit register. A prescaler derives the one-second step from pulses of a slow clock, 32768 of them per second by default. A 32-bit alarm compare value sits beside the counter. A control register holds the counter enable, alarm enable, the two interrupt enables, two sticky event flags and a read-only write-ready bit. A 32-bit scratch register keeps whatever software last wrote, so software can tell whether the clock state survived.

Register writes are protected. Each accepted write starts a busy window that lasts a set number of slow-clock pulses, and the write-ready bit reads 0 during that window. In the locked variant, each write must also be preceded by a key write that arms a one-shot unlock bit. The slow clock enters as a single-cycle enable pulse, `slow_tick`, that is synchronous to the bus clock. The bus is a plain strobe interface with no back-pressure: a write either takes effect in its cycle or is dropped, and read data appears one cycle after the read strobe. The interrupt is a level output.

Top module: `rtc_core`

## Requirements
- R1: After reset, the control register reads 0x80 (only write-ready set), the seconds, alarm, scratch and unlock registers all read 0, and `irq` is low.
- R2: When counter enable (control bit 0) is set, the seconds register (offset 0x04) increases by one for every TICKS_PER_SEC `slow_tick` pulses and wraps from 0xFFFFFFFF to 0. When the enable is clear, the seconds register holds its value.
- R3: Write-ready is control bit 7. A register write is accepted only while this bit is 1. After an accepted write, the bit reads 0 until BUSY_TICKS further `slow_tick` pulses have occurred.
- R4: Writing 0xA55A to offset 0x3C while ready sets bit 31 of that register. With UNLOCK_EN=1, writes to the control, seconds, alarm and scratch registers are ignored unless bit 31 is set, and bit 31 clears after every accepted write.
- R5: The alarm flag (control bit 4) and the 1 Hz flag (control bit 6) are cleared only by an accepted control write that has 0 in that bit. Writing 1 to either flag leaves it unchanged.
- R6: The 1 Hz flag is set on every step of the seconds counter.
- R7: The alarm flag is set when alarm enable (control bit 2) is 1 and the seconds counter steps onto the value in the alarm register (offset 0x08).
- R8: `irq` is high while the alarm flag and alarm interrupt enable (bit 3) are both set, or while the 1 Hz flag and 1 Hz interrupt enable (bit 5) are both set.
- R9: The scratch register (offset 0x34) returns the last value accepted for it.
- R10: Read data is registered and appears the cycle after `rd_en`. Two back-to-back seconds reads with no step between them return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle pulse per slow-clock period |
| addr | input | ADDR_W | Byte offset of the register |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |
| irq | output | 1 | Level interrupt |

## Verification
The hardest states to reach from the ports are those that need write protection and time passing at the same moment. Two cases stand out: clearing a flag with a write while the counter keeps stepping, and the alarm matching after several seconds. To reach them, the bench shortens the second to 64 slow pulses and pulses `slow_tick` every fourth clock. Every write goes through a helper that polls write-ready and then arms the unlock. The waits are chosen so that each sample falls mid-second, well away from a step. Before any flag is cleared, the counter is stopped in the same write, so no new step can set the flag again before it is read.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int DATA_W = 32;
  localparam logic [5:0] OFF_CTRL    = 6'h00;
  localparam logic [5:0] OFF_SECS    = 6'h04;
  localparam logic [5:0] OFF_ALARM   = 6'h08;
  localparam logic [5:0] OFF_SCRATCH = 6'h34;
  localparam logic [5:0] OFF_UNLOCK  = 6'h3C;
  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h0000_A55A;
  localparam int B_EN   = 0;
  localparam int B_AE   = 2;
  localparam int B_AIE  = 3;
  localparam int B_AF   = 4;
  localparam int B_HIE  = 5;
  localparam int B_HF   = 6;
  localparam int B_WRDY = 7;
  localparam int B_ULK  = 31;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_tick,
  input  logic run,
  input  logic restart,
  output logic sec_pulse
);
  localparam int CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q;

  assign sec_pulse = run && slow_tick && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) cnt_q <= '0;
    else if (run && slow_tick) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/rtc_wr_gate.sv
module rtc_wr_gate #(
  parameter int BUSY_TICKS = 3,
  parameter bit UNLOCK_EN  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_tick,
  input  logic key_wr,
  input  logic reg_wr,
  output logic wr_ok,
  output logic ready,
  output logic unlocked
);
  localparam int BW = $clog2(BUSY_TICKS + 1);
  localparam logic [BW-1:0] BUSY_LOAD = BW'(BUSY_TICKS);

  logic [BW-1:0] busy_q;

  assign ready = (busy_q == '0);

  generate
    if (UNLOCK_EN) begin : g_locked
      logic ulk_q;
      assign unlocked = ulk_q;
      assign wr_ok    = reg_wr && ready && ulk_q;
      always_ff @(posedge clk) begin
        if (!rst_n || wr_ok) ulk_q <= 1'b0;
        else if (key_wr && ready) ulk_q <= 1'b1;
      end
    end else begin : g_open
      assign unlocked = 1'b0;
      assign wr_ok    = reg_wr && ready;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) busy_q <= '0;
    else if (wr_ok) busy_q <= BUSY_LOAD;
    else if (slow_tick && busy_q != '0) busy_q <= busy_q - 1'b1;
  end
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int ADDR_W        = 6,
  parameter int TICKS_PER_SEC = 32768,
  parameter int BUSY_TICKS    = 3,
  parameter bit UNLOCK_EN     = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  output logic [31:0]       rd_data,
  output logic              irq
);
  logic [5:0] off;
  assign off = 6'(addr);

  logic sel_ctrl, sel_secs, sel_alarm, sel_scr, sel_ulk;
  assign sel_ctrl  = (off == OFF_CTRL);
  assign sel_secs  = (off == OFF_SECS);
  assign sel_alarm = (off == OFF_ALARM);
  assign sel_scr   = (off == OFF_SCRATCH);
  assign sel_ulk   = (off == OFF_UNLOCK);

  logic key_wr, reg_wr, wr_ok, ready, unlocked, sec_pulse;
  assign key_wr = wr_en && sel_ulk && (wr_data == UNLOCK_KEY);
  assign reg_wr = wr_en && (sel_ctrl || sel_secs || sel_alarm || sel_scr);

  logic [31:0] sec_q, alarm_q, scr_q;
  logic en_q, ae_q, aie_q, af_q, hie_q, hf_q;
  logic sec_load, ctrl_wr;
  assign sec_load = wr_ok && sel_secs;
  assign ctrl_wr  = wr_ok && sel_ctrl;

  rtc_wr_gate #(.BUSY_TICKS(BUSY_TICKS), .UNLOCK_EN(UNLOCK_EN)) u_gate (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .key_wr(key_wr),
    .reg_wr(reg_wr), .wr_ok(wr_ok), .ready(ready), .unlocked(unlocked)
  );

  rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .run(en_q),
    .restart(sec_load), .sec_pulse(sec_pulse)
  );

  logic [31:0] sec_next;
  logic alarm_hit;
  assign sec_next  = sec_q + 32'd1;
  assign alarm_hit = sec_pulse && ae_q && (sec_next == alarm_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q <= '0; alarm_q <= '0; scr_q <= '0;
    end else begin
      if (sec_load) sec_q <= wr_data;
      else if (sec_pulse) sec_q <= sec_next;
      if (wr_ok && sel_alarm) alarm_q <= wr_data;
      if (wr_ok && sel_scr) scr_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; ae_q <= 1'b0; aie_q <= 1'b0; hie_q <= 1'b0;
      af_q <= 1'b0; hf_q <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        en_q  <= wr_data[B_EN];
        ae_q  <= wr_data[B_AE];
        aie_q <= wr_data[B_AIE];
        hie_q <= wr_data[B_HIE];
      end
      af_q <= alarm_hit | (af_q & ~(ctrl_wr & ~wr_data[B_AF]));
      hf_q <= sec_pulse | (hf_q & ~(ctrl_wr & ~wr_data[B_HF]));
    end
  end

  logic [31:0] ctrl_view, ulk_view;
  always_comb begin
    ctrl_view         = '0;
    ctrl_view[B_EN]   = en_q;
    ctrl_view[B_AE]   = ae_q;
    ctrl_view[B_AIE]  = aie_q;
    ctrl_view[B_AF]   = af_q;
    ctrl_view[B_HIE]  = hie_q;
    ctrl_view[B_HF]   = hf_q;
    ctrl_view[B_WRDY] = ready;
    ulk_view          = '0;
    ulk_view[B_ULK]   = unlocked;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_en) begin
      unique case (1'b1)
        sel_ctrl:  rd_data <= ctrl_view;
        sel_secs:  rd_data <= sec_q;
        sel_alarm: rd_data <= alarm_q;
        sel_scr:   rd_data <= scr_q;
        sel_ulk:   rd_data <= ulk_view;
        default:   rd_data <= '0;
      endcase
    end
  end

  assign irq = (af_q & aie_q) | (hf_q & hie_q);
endmodule

// File: rtl/rtc_core_sva.sv
module rtc_core_sva #(
  parameter bit UNLOCK_EN = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_ok,
  input logic        ready,
  input logic        unlocked,
  input logic        sec_load,
  input logic        ctrl_wr,
  input logic [31:0] wr_data,
  input logic [31:0] sec_q,
  input logic        en_q,
  input logic        hf_q,
  input logic        af_q
);
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> !ready); // R3

  AST_ACCEPT_WHEN_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |-> (ready && (unlocked || !UNLOCK_EN))); // R4

  AST_UNLOCK_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> !unlocked); // R4

  AST_SEC_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(sec_load) && sec_q != $past(sec_q)) |-> (sec_q == $past(sec_q) + 32'd1)); // R2

  AST_SEC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !sec_load) |=> $stable(sec_q)); // R2

  AST_HF_CLEAR_BY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hf_q) && !hf_q) |-> $past(ctrl_wr && !wr_data[6])); // R5

  AST_AF_CLEAR_BY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(af_q) && !af_q) |-> $past(ctrl_wr && !wr_data[4])); // R5
endmodule

bind rtc_core rtc_core_sva #(.UNLOCK_EN(UNLOCK_EN)) u_sva (
  .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .ready(ready), .unlocked(unlocked),
  .sec_load(sec_load), .ctrl_wr(ctrl_wr), .wr_data(wr_data), .sec_q(sec_q),
  .en_q(en_q), .hf_q(hf_q), .af_q(af_q)
);

// File: tb/rtc_core_tb.sv
module rtc_core_tb;
  localparam int TPS = 64;
  localparam int BUSY = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slow_tick = 1'b0;
  logic [5:0] addr = '0;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic rd_en = 1'b0;
  logic [31:0] rd_data;
  logic irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rtc_core #(.ADDR_W(6), .TICKS_PER_SEC(TPS), .BUSY_TICKS(BUSY), .UNLOCK_EN(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
  );

  initial begin
    forever begin
      @(negedge clk); slow_tick = 1'b0;
      @(negedge clk);
      @(negedge clk);
      @(negedge clk); slow_tick = 1'b1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic wait_ready();
    logic [31:0] c;
    for (int i = 0; i < 100; i++) begin
      bus_rd(6'h00, c);
      if (c[7]) break;
    end
  endtask

  task automatic safe_wr(input logic [5:0] a, input logic [31:0] d);
    wait_ready();
    bus_wr(6'h3C, 32'hA55A);
    bus_wr(a, d);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    bus_rd(6'h00, v); check(v == 32'h80, "R1 ctrl", v, 32'h80);
    bus_rd(6'h04, v); check(v == 0, "R1 secs", v, 0);
    bus_rd(6'h08, v); check(v == 0, "R1 alarm", v, 0);
    bus_rd(6'h34, v); check(v == 0, "R1 scratch", v, 0);
    bus_rd(6'h3C, v); check(v == 0, "R1 unlock", v, 0);
    check(irq == 1'b0, "R1 irq", 32'(irq), 0);
  endtask

  task automatic t_protect();
    logic [31:0] v;
    safe_wr(6'h34, 32'h1234_5678);
    bus_rd(6'h00, v); check(v[7] == 1'b0, "R3 busy after write", 32'(v[7]), 0);
    bus_rd(6'h3C, v); check(v == 0, "R4 unlock cleared", v, 0);
    repeat (16) @(negedge clk);
    bus_rd(6'h00, v); check(v[7] == 1'b1, "R3 ready again", 32'(v[7]), 1);
    bus_rd(6'h34, v); check(v == 32'h1234_5678, "R9 scratch keeps", v, 32'h1234_5678);
    bus_wr(6'h34, 32'hDEAD);
    bus_rd(6'h34, v); check(v == 32'h1234_5678, "R4 locked write ignored", v, 32'h1234_5678);
    bus_wr(6'h3C, 32'h1111);
    bus_rd(6'h3C, v); check(v == 0, "R4 wrong key", v, 0);
    bus_wr(6'h3C, 32'hA55A);
    bus_rd(6'h3C, v); check(v == 32'h8000_0000, "R4 unlock set", v, 32'h8000_0000);
    bus_wr(6'h34, 32'h5);
    bus_wr(6'h34, 32'h6);
    bus_rd(6'h34, v); check(v == 32'h5, "R4 R9 second write ignored", v, 32'h5);
  endtask

  task automatic t_count();
    logic [31:0] v, v2;
    safe_wr(6'h04, 32'hFFFF_FFFE);
    safe_wr(6'h00, 32'h1);
    repeat (128) @(negedge clk);
    bus_rd(6'h04, v); check(v == 32'hFFFF_FFFE, "R2 before step", v, 32'hFFFF_FFFE);
    repeat (256) @(negedge clk);
    bus_rd(6'h04, v); bus_rd(6'h04, v2);
    check(v == 32'hFFFF_FFFF, "R2 one step", v, 32'hFFFF_FFFF);
    check(v2 == v, "R10 back-to-back", v2, v);
    repeat (256) @(negedge clk);
    bus_rd(6'h04, v); check(v == 0, "R2 wrap", v, 0);
    bus_rd(6'h00, v);
    check(v[6] == 1'b1, "R6 hz flag", 32'(v[6]), 1);
    check(irq == 1'b0, "R8 no irq without enable", 32'(irq), 0);
    safe_wr(6'h00, 32'h41);
    bus_rd(6'h00, v); check(v[6] == 1'b1, "R5 write one keeps", 32'(v[6]), 1);
    safe_wr(6'h00, 32'h0);
    bus_rd(6'h00, v); check(v[6] == 1'b0, "R5 write zero clears", 32'(v[6]), 0);
    bus_rd(6'h04, v);
    repeat (600) @(negedge clk);
    bus_rd(6'h04, v2); check(v2 == v, "R2 frozen", v2, v);
  endtask

  task automatic t_alarm();
    logic [31:0] v;
    safe_wr(6'h04, 32'd10);
    safe_wr(6'h08, 32'd12);
    safe_wr(6'h00, 32'h0D);
    repeat (128) @(negedge clk);
    bus_rd(6'h00, v); check(v[4] == 1'b0, "R7 not yet", 32'(v[4]), 0);
    check(irq == 1'b0, "R8 irq low", 32'(irq), 0);
    repeat (512) @(negedge clk);
    bus_rd(6'h00, v); check(v[4] == 1'b1, "R7 alarm flag", 32'(v[4]), 1);
    check(irq == 1'b1, "R8 alarm irq", 32'(irq), 1);
    bus_rd(6'h04, v); check(v == 32'd12, "R2 R7 secs at alarm", v, 32'd12);
    safe_wr(6'h00, 32'h0C);
    bus_rd(6'h00, v); check(v[4] == 1'b0, "R5 alarm clear", 32'(v[4]), 0);
    check(irq == 1'b0, "R8 irq drops", 32'(irq), 0);
    safe_wr(6'h00, 32'h21);
    repeat (300) @(negedge clk);
    check(irq == 1'b1, "R8 R6 hz irq", 32'(irq), 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_protect();
    t_count();
    t_alarm();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule